// File: doc/BRIEF.md
# NaN payload special-case resolver

This unit sits beside a single-precision add, subtract, multiply and divide datapath. It decides whether the result of the current operation is a special value that must replace the normal arithmetic result. It takes two packed floating-point operands and an operation select. It returns an override flag and the value to substitute.

Errors are never trapped. They are carried only in the values the unit produces, so a program sees the same outcome whatever vector length it runs on.

- **Invalid operations** produce a quiet NaN. The payload of that NaN has one bit set per error class.
- **Incoming NaNs** are merged by OR-ing their payloads. The merged result is therefore the same when the operands are swapped.
- **Division of a nonzero finite value by zero** gives a signed infinity.

Normal-number arithmetic and rounding stay in the datapath. The unit has one registered stage with a valid-in/valid-out handshake and a synchronous active-high reset.

Top module: `fp_special_resolve`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `out_valid`, `out_override` and `out_value` are all zero.
- R2: `out_valid` is `in_valid` delayed by exactly one clock. The result shown with it belongs to the operands presented with that `in_valid`. `op_sel` encodes 00 = add, 01 = subtract, 10 = multiply, 11 = divide.
- R3: When both operands are NaN (exponent all ones, mantissa nonzero), the result is overridden with a NaN.
  - Its mantissa is the OR of both input mantissas with bit 22 (the quiet bit) set.
  - Its sign is the OR of both signs.
  - Swapping the operands gives an identical result.
- R4: When exactly one operand is NaN, that NaN is returned with its sign and payload intact and only bit 22 forced to one. This holds for every operation, including cases that would otherwise be invalid.
- R5: A signalling NaN input (bit 22 clear) is made quiet by setting bit 22. All its other mantissa bits are kept.
- R6: For add or subtract of two infinities whose effective signs differ (the sign of the second operand is inverted for subtract), the result is the invalid NaN 0x7FC00001. That is a positive sign, bit 22 set and payload bit 0 (the infinity/division class) set.
- R7: For multiply of a zero by an infinity, in either order and with any signs, the result is the invalid NaN 0x7FC00001.
- R8: For divide, zero by zero and infinity by infinity, with any signs, give the invalid NaN 0x7FC00001.
- R9: For divide, a nonzero finite dividend (normal or subnormal) over a zero divisor gives an infinity (0x7F800000 magnitude) whose sign is the XOR of the operand signs.
- R10: Any other operand combination gives `out_override` = 0 and `out_value` = 0. Examples are finite arithmetic, infinity plus infinity of the same sign, zero over a finite value, and infinity over zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation are present this cycle |
| op_a | input | 32 | First operand, packed single precision |
| op_b | input | 32 | Second operand, packed single precision |
| op_sel | input | 2 | Operation: 00 add, 01 sub, 10 mul, 11 div |
| out_valid | output | 1 | Result registered from the previous `in_valid` |
| out_override | output | 1 | Special-case result replaces the datapath result |
| out_value | output | 32 | Special-case value, zero when not overriding |

## Verification
The operand pairs are grouped by what they distinguish:
- **Two NaNs with disjoint payload bits**, sent in both operand orders, tell an OR merge apart from a pick-one merge. They also show whether the result depends on operand order.
- **Signalling NaNs with scattered payload bits** show that quieting touches only the quiet bit.
- **A NaN paired with an infinity** shows that NaN propagation has priority over invalid detection.
- **Infinity pairs under add and subtract, with matching and opposing signs,** separate the effective-sign rule for invalid results from the cases that must fall through.
- **Divide-by-zero with each sign combination and with a subnormal dividend** pins down the sign of the infinity. Zero over a finite value and infinity over zero confirm that no override is raised.
- **Back-to-back and gapped issue** check the one-cycle pairing of inputs and results.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_MUL = 2'b10,
      OP_DIV = 2'b11
   } fpsr_op_e;

   typedef struct packed {
      logic is_nan;
      logic is_inf;
      logic is_zero;
   } fpsr_class_t;

   // Payload class bit positions within the mantissa
   localparam int PL_INF_DIV  = 0;
   localparam int PL_LOG_POW  = 1;
   localparam int PL_MATH_FN  = 2;
   localparam int PL_EXPLICIT = 3;

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
   import fpsr_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] val_i,
   output fpsr_class_t          cls_o
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_ones;
   logic             exp_zero;
   logic             man_zero;

   assign exp_f    = val_i[EXP_W+MAN_W-1:MAN_W];
   assign man_f    = val_i[MAN_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_zero = ~|exp_f;
   assign man_zero = ~|man_f;

   always_comb begin
      cls_o.is_nan  = exp_ones & ~man_zero;
      cls_o.is_inf  = exp_ones &  man_zero;
      cls_o.is_zero = exp_zero &  man_zero;
   end

endmodule

// File: rtl/fpsr_resolve.sv
module fpsr_resolve
   import fpsr_pkg::*;
#(
   parameter int EXP_W       = 8,
   parameter int MAN_W       = 23,
   parameter int INFDIV_BIT  = PL_INF_DIV,
   parameter bit NAN_SIGN_OR = 1'b1
) (
   input  logic [EXP_W+MAN_W:0] a_i,
   input  logic [EXP_W+MAN_W:0] b_i,
   input  fpsr_op_e             op_i,
   input  fpsr_class_t          ca_i,
   input  fpsr_class_t          cb_i,
   output logic                 ovr_o,
   output logic [EXP_W+MAN_W:0] val_o
);

   localparam int SIGN_POS = EXP_W + MAN_W;
   localparam logic [MAN_W-1:0] QUIET_MASK  = MAN_W'(1) << (MAN_W - 1);
   localparam logic [MAN_W-1:0] INFDIV_MASK = MAN_W'(1) << INFDIV_BIT;

   logic             sa, sb, sb_eff;
   logic             nan_sign;
   logic [MAN_W-1:0] nan_man;
   logic             invalid;
   logic             div_zero;

   assign sa     = a_i[SIGN_POS];
   assign sb     = b_i[SIGN_POS];
   assign sb_eff = sb ^ (op_i == OP_SUB);

   // Sign of a NaN result: a variant picks the merge rule
   generate
      if (NAN_SIGN_OR) begin : g_sign_or
         assign nan_sign = (ca_i.is_nan & sa) | (cb_i.is_nan & sb);
      end else begin : g_sign_first
         assign nan_sign = ca_i.is_nan ? sa : sb;
      end
   endgenerate

   // Payloads of whichever operands are NaN, merged, then quieted
   assign nan_man = (ca_i.is_nan ? a_i[MAN_W-1:0] : '0)
                  | (cb_i.is_nan ? b_i[MAN_W-1:0] : '0)
                  | QUIET_MASK;

   always_comb begin
      unique case (op_i)
         OP_ADD, OP_SUB: invalid = ca_i.is_inf & cb_i.is_inf & (sa != sb_eff);
         OP_MUL:         invalid = (ca_i.is_zero & cb_i.is_inf) | (ca_i.is_inf & cb_i.is_zero);
         OP_DIV:         invalid = (ca_i.is_zero & cb_i.is_zero) | (ca_i.is_inf & cb_i.is_inf);
         default:        invalid = 1'b0;
      endcase
   end

   assign div_zero = (op_i == OP_DIV) & cb_i.is_zero & ~ca_i.is_zero
                   & ~ca_i.is_inf & ~ca_i.is_nan;

   // Priority: NaN propagation, then invalid, then divide by zero
   always_comb begin
      ovr_o = 1'b0;
      val_o = '0;
      if (ca_i.is_nan | cb_i.is_nan) begin
         ovr_o = 1'b1;
         val_o = {nan_sign, {EXP_W{1'b1}}, nan_man};
      end else if (invalid) begin
         ovr_o = 1'b1;
         val_o = {1'b0, {EXP_W{1'b1}}, QUIET_MASK | INFDIV_MASK};
      end else if (div_zero) begin
         ovr_o = 1'b1;
         val_o = {sa ^ sb, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      end
   end

endmodule

// File: rtl/fp_special_resolve.sv
module fp_special_resolve
   import fpsr_pkg::*;
#(
   parameter int EXP_W       = 8,
   parameter int MAN_W       = 23,
   parameter bit NAN_SIGN_OR = 1'b1,
   parameter bit RESET_DATA  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [EXP_W+MAN_W:0] op_a,
   input  logic [EXP_W+MAN_W:0] op_b,
   input  logic [1:0]           op_sel,
   output logic                 out_valid,
   output logic                 out_override,
   output logic [EXP_W+MAN_W:0] out_value
);

   localparam int W        = 1 + EXP_W + MAN_W;
   localparam int QBIT     = MAN_W - 1;
   localparam int N_OPND   = 2;
   localparam logic [W-1:0] INVALID_NAN =
      {1'b0, {EXP_W{1'b1}}, (MAN_W'(1) << QBIT) | (MAN_W'(1) << PL_INF_DIV)};

   initial begin : elab_checks
      assert (EXP_W >= 2) else $error("EXP_W too small");
      assert (MAN_W >= 5) else $error("MAN_W too small for payload classes");
      assert (PL_EXPLICIT < QBIT && PL_MATH_FN < QBIT &&
              PL_LOG_POW < QBIT && PL_INF_DIV < QBIT)
         else $error("payload class bit collides with quiet bit");
      assert (PL_INF_DIV != PL_LOG_POW && PL_LOG_POW != PL_MATH_FN &&
              PL_MATH_FN != PL_EXPLICIT && PL_INF_DIV != PL_EXPLICIT)
         else $error("payload class bits must be distinct");
   end

   logic [W-1:0] opnd [N_OPND];
   fpsr_class_t  cls  [N_OPND];
   logic         ovr_d;
   logic [W-1:0] val_d;

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   generate
      for (genvar i = 0; i < N_OPND; i++) begin : g_cls
         fpsr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val_i (opnd[i]),
            .cls_o (cls[i])
         );
      end
   endgenerate

   fpsr_resolve #(
      .EXP_W       (EXP_W),
      .MAN_W       (MAN_W),
      .INFDIV_BIT  (PL_INF_DIV),
      .NAN_SIGN_OR (NAN_SIGN_OR)
   ) u_resolve (
      .a_i   (op_a),
      .b_i   (op_b),
      .op_i  (fpsr_op_e'(op_sel)),
      .ca_i  (cls[0]),
      .cb_i  (cls[1]),
      .ovr_o (ovr_d),
      .val_o (val_d)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
   end

   generate
      if (RESET_DATA) begin : g_data_rst
         always_ff @(posedge clk) begin
            if (rst) begin
               out_override <= 1'b0;
               out_value    <= '0;
            end else if (in_valid) begin
               out_override <= ovr_d;
               out_value    <= val_d;
            end
         end
      end else begin : g_data_norst
         always_ff @(posedge clk) begin
            if (in_valid) begin
               out_override <= ovr_d;
               out_value    <= val_d;
            end
         end
      end
   endgenerate

   // Port-level operand decode for the checks below
   logic a_nan, b_nan, a_zero, b_zero, a_inf, b_inf;
   assign a_nan  = (&op_a[W-2:MAN_W]) & (|op_a[MAN_W-1:0]);
   assign b_nan  = (&op_b[W-2:MAN_W]) & (|op_b[MAN_W-1:0]);
   assign a_inf  = (&op_a[W-2:MAN_W]) & ~(|op_a[MAN_W-1:0]);
   assign b_inf  = (&op_b[W-2:MAN_W]) & ~(|op_b[MAN_W-1:0]);
   assign a_zero = ~(|op_a[W-2:0]);
   assign b_zero = ~(|op_b[W-2:0]);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);  // R2
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);  // R2
   AST_NAN_OR_MERGE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && a_nan && b_nan) |=> (out_override &&
         out_value[MAN_W-1:0] == ($past(op_a[MAN_W-1:0] | op_b[MAN_W-1:0]) | (MAN_W'(1) << QBIT))));  // R3
   AST_ONE_NAN_PASS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && a_nan && !b_nan) |=> (out_override &&
         out_value == ($past(op_a) | (W'(1) << QBIT))));  // R4
   AST_DIV_INVALID: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b11 && ((a_inf && b_inf) || (a_zero && b_zero)))
         |=> (out_override && out_value == INVALID_NAN));  // R8
   AST_DIV_ZERO_INF: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b11 && b_zero && !a_zero && !a_inf && !a_nan)
         |=> (out_override && out_value ==
              {$past(op_a[W-1] ^ op_b[W-1]), {EXP_W{1'b1}}, {MAN_W{1'b0}}}));  // R9
   AST_NO_OVR_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_override) |-> (out_value == '0));  // R10

endmodule

// File: tb/tb_fp_special_resolve.sv
`timescale 1ns/1ps
module tb_fp_special_resolve;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [1:0]  op_sel = '0;
   logic        out_valid;
   logic        out_override;
   logic [31:0] out_value;

   int checks = 0;
   int failures = 0;
   bit mon_en = 1'b0;
   bit finished = 1'b0;

   logic [32:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   fp_special_resolve dut (
      .clk, .rst, .in_valid, .op_a, .op_b, .op_sel,
      .out_valid, .out_override, .out_value
   );

   task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got ovr=%0d val=%08h expected ovr=%0d val=%08h",
                  tag, got[32], got[31:0], exp[32], exp[31:0]);
      end
   endtask

   task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                       input logic ovr, input logic [31:0] v, input string tag);
      @(posedge clk); #1;
      in_valid = 1'b1; op_a = a; op_b = b; op_sel = op;
      exp_q.push_back({ovr, v});
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b0;
      end
   endtask

   // Monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (mon_en && !rst && out_valid) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R2: unexpected out_valid, got val=%08h expected no result", out_value);
         end else begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {out_override, out_value}, e);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin : watchdog
      #200000;
      checks++; failures++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   localparam logic [31:0] INV  = 32'h7FC00001;
   localparam logic [31:0] PINF = 32'h7F800000;
   localparam logic [31:0] NINF = 32'hFF800000;
   localparam logic [31:0] ONE  = 32'h3F800000;
   localparam logic [31:0] MONE = 32'hBF800000;

   initial begin : stim
      // R1: reset state, even with a NaN presented during reset
      in_valid = 1'b1; op_a = 32'h7FC00004; op_b = 32'h7FC00008;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 during reset", {out_override, out_value}, 33'h0);
      checks++;
      if (out_valid !== 1'b0) begin
         failures++;
         $display("FAIL R1: out_valid got %0d expected 0", out_valid);
      end
      #1; rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check("R1 after reset", {out_valid, out_override, out_value[30:0]}, 33'h0);
      mon_en = 1'b1;

      // R3: OR merge, both operand orders
      send(32'h7FC00004, 32'h7FC00008, 2'b00, 1'b1, 32'h7FC0000C, "R3 add a,b");
      send(32'h7FC00008, 32'h7FC00004, 2'b00, 1'b1, 32'h7FC0000C, "R3 add b,a");
      send(32'hFFC00001, 32'h7FC00002, 2'b10, 1'b1, 32'hFFC00003, "R3 mul sign or");
      send(32'h7FC00002, 32'hFFC00001, 2'b10, 1'b1, 32'hFFC00003, "R3 mul swapped");
      // R5: signalling NaNs quieted, payload kept
      send(32'h7F800005, ONE, 2'b00, 1'b1, 32'h7FC00005, "R5 snan add");
      send(32'h7F800010, 32'hFFA00001, 2'b11, 1'b1, 32'hFFE00011, "R5 R3 two snan");
      idle(2);
      // R4: single NaN passes through
      send(ONE, 32'hFFC12345, 2'b11, 1'b1, 32'hFFC12345, "R4 div b nan");
      send(PINF, 32'hFFC00002, 2'b01, 1'b1, 32'hFFC00002, "R4 nan beats inf");
      send(32'h7F812345, 32'h00000000, 2'b10, 1'b1, 32'h7FC12345, "R4 snan times zero");
      // R6: infinity add/sub
      send(PINF, PINF, 2'b01, 1'b1, INV, "R6 inf-inf");
      send(PINF, NINF, 2'b00, 1'b1, INV, "R6 inf+-inf");
      send(PINF, PINF, 2'b00, 1'b0, 32'h0, "R10 inf+inf");
      send(NINF, PINF, 2'b01, 1'b0, 32'h0, "R10 -inf-inf");
      idle(1);
      // R7: zero times infinity
      send(32'h00000000, PINF, 2'b10, 1'b1, INV, "R7 0*inf");
      send(NINF, 32'h80000000, 2'b10, 1'b1, INV, "R7 -inf*-0");
      // R8: divide invalid
      send(32'h00000000, 32'h80000000, 2'b11, 1'b1, INV, "R8 0/0");
      send(PINF, NINF, 2'b11, 1'b1, INV, "R8 inf/inf");
      // R9: divide by zero
      send(ONE, 32'h00000000, 2'b11, 1'b1, PINF, "R9 1/0");
      send(MONE, 32'h00000000, 2'b11, 1'b1, NINF, "R9 -1/0");
      send(ONE, 32'h80000000, 2'b11, 1'b1, NINF, "R9 1/-0");
      send(32'h00000001, 32'h80000000, 2'b11, 1'b1, NINF, "R9 subnormal/-0");
      // R10: no override
      send(ONE, 32'h40000000, 2'b00, 1'b0, 32'h0, "R10 finite add");
      send(32'h00000000, ONE, 2'b11, 1'b0, 32'h0, "R10 0/1");
      send(PINF, 32'h00000000, 2'b11, 1'b0, 32'h0, "R10 inf/0");
      send(32'h00000000, ONE, 2'b10, 1'b0, 32'h0, "R10 0*1");
      idle(3);

      // R2: every issued item produced exactly one result
      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R2: pending results got %0d expected 0", exp_q.size());
      end
      checks++;
      if (out_valid !== 1'b0) begin
         failures++;
         $display("FAIL R2: out_valid when idle got %0d expected 0", out_valid);
      end
      finish_run();
   end

endmodule